// File: doc/BRIEF.md
# Multi-channel ADC capture front-end

This block sits behind an eight-lane simultaneous-sampling converter whose parallel words all change on one shared conversion clock. Every clock it registers one word per lane together with the per-lane run controls and the shared active-low output enable. It then emits one result per lane in that lane's fixed slot of the output bus, so the slot index is the channel tag. Each result carries a two's complement sample, a valid flag and an over-range flag.

The converter discards its pipeline contents whenever a lane is put to sleep. Its outputs float while the output enable is off. The block therefore tracks, separately for every lane, whether the word on the bus can be trusted. A lane that leaves standby must let the converter's seven-clock pipeline refill before its samples count again. An output-enable change costs one extra settling clock. Words that are not trusted come out as zero, with valid and over-range both low.

Top module: `adcf_capture`

## Requirements
- R1: While reset is high, and on the first clock after it, every lane drives valid low, over-range low and data zero.
- R2: A lane's output word is its input code with bit 9 (the MSB) inverted, which turns offset binary into two's complement. Input 0x200 gives 0x000, 0x000 gives 0x200 and 0x3FF gives 0x1FF. The result appears on the second rising edge after the code is presented, and all lanes update on the same edge.
- R3: Over-range is high for a valid lane exactly when its raw code was 0x000 or 0x3FF. It is low for every other code and for invalid lanes.
- R4: Driving a lane's run bit low (standby) makes that lane's valid, over-range and data all zero from the second rising edge after the change.
- R5: After a lane's run bit returns high, its valid stays low for the first 8 rising edges and goes high at the 9th. This covers the seven-clock refill plus input and output registration.
- R6: Driving the output enable high (disabled) makes every lane invalid, with data and over-range zero, from the second rising edge.
- R7: After the output enable returns low, valid stays low for 2 rising edges and returns at the 3rd, which is one extra settling clock. A disable period does not restart any lane's refill count.
- R8: Standby on one lane leaves the valid flags and data of all other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_code | input | NCH*W (80) | Raw offset-binary words, lane i at bits [i*W +: W] |
| ch_run | input | NCH (8) | Per-lane run control, 1 = converting, 0 = standby |
| out_en_n | input | 1 | Shared output enable, 0 = converter outputs driven |
| smp_data | output | NCH*W (80) | Two's complement samples, lane i at bits [i*W +: W] |
| smp_valid | output | NCH (8) | Per-lane sample valid |
| smp_ovr | output | NCH (8) | Per-lane over-range (code at either rail) |

## Verification
On every cycle, the assertions check the following for each lane:
- Standby and output disable always blank the lane on the next edge.
- A valid word is the previous captured code with its MSB flipped.
- Over-range never appears without valid.
- The refill counter never reports ready while the lane is asleep.

Only the directed scenarios can show the exact edge counts: the 9-edge refill after standby exit, the 3-edge return after the output is re-enabled, and the fact that a disable period leaves the counters alone. The same holds for the rail codes raising over-range and for lanes staying independent of one another.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  localparam int unsigned DEF_CHANNELS = 8;
  localparam int unsigned DEF_WIDTH    = 10;
  localparam int unsigned DEF_LATENCY  = 7;

  // width of a down-counter that must hold the value lat
  function automatic int unsigned cnt_bits(input int unsigned lat);
    return (lat < 2) ? 1 : $clog2(lat + 1);
  endfunction
endpackage

// File: rtl/adcf_lane_timer.sv
module adcf_lane_timer
  import adcf_pkg::*;
#(
  parameter int unsigned LAT = DEF_LATENCY
) (
  input  logic clk,
  input  logic rst,
  input  logic run_q,
  output logic ready
);
  localparam int unsigned CW = cnt_bits(LAT);
  localparam logic [CW-1:0] FULL = CW'(LAT);

  logic [CW-1:0] cnt;

  // reload while asleep, count down once awake, hold at zero
  always_ff @(posedge clk) begin
    if (rst)                cnt <= FULL;
    else if (!run_q)        cnt <= FULL;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign ready = (cnt == '0);

  // R5: a lane asleep on this edge is never ready on the next
  a_r5_sleep_not_ready: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !ready);
  // R5: readiness only follows a cycle in which the lane was running
  a_r5_ready_after_run: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(run_q));
endmodule

// File: rtl/adcf_oe_gate.sv
module adcf_oe_gate (
  input  logic clk,
  input  logic rst,
  input  logic oen_q,
  output logic open
);
  logic settle;

  // one settling clock after the enable returns
  always_ff @(posedge clk) begin
    if (rst) settle <= 1'b1;
    else     settle <= oen_q;
  end

  assign open = !oen_q && !settle;

  // R7: the edge the enable returns is still closed
  a_r7_extra_clk: assert property (@(posedge clk) disable iff (rst)
    $fell(oen_q) |-> !open);
  // R6: disabled means closed
  a_r6_closed: assert property (@(posedge clk) disable iff (rst)
    oen_q |-> !open);
endmodule

// File: rtl/adcf_code_conv.sv
module adcf_code_conv
  import adcf_pkg::*;
#(
  parameter int unsigned W = DEF_WIDTH
) (
  input  logic [W-1:0] code,
  output logic [W-1:0] tc,
  output logic         rail
);
  localparam logic [W-1:0] LO = '0;
  localparam logic [W-1:0] HI = '1;

  always_comb begin
    tc       = code;
    tc[W-1]  = ~code[W-1];
    rail     = (code == LO) || (code == HI);
  end
endmodule

// File: rtl/adcf_capture.sv
module adcf_capture
  import adcf_pkg::*;
#(
  parameter int unsigned NCH = DEF_CHANNELS,
  parameter int unsigned W   = DEF_WIDTH,
  parameter int unsigned LAT = DEF_LATENCY
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH*W-1:0] adc_code,
  input  logic [NCH-1:0]   ch_run,
  input  logic             out_en_n,
  output logic [NCH*W-1:0] smp_data,
  output logic [NCH-1:0]   smp_valid,
  output logic [NCH-1:0]   smp_ovr
);
  localparam int unsigned BUSW = NCH * W;

  logic [BUSW-1:0] in_q;
  logic [NCH-1:0]  run_q;
  logic            oen_q;
  logic            open;

  // input capture stage: all lanes on one edge
  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      run_q <= '0;
      oen_q <= 1'b1;
    end else begin
      in_q  <= adc_code;
      run_q <= ch_run;
      oen_q <= out_en_n;
    end
  end

  adcf_oe_gate u_gate (
    .clk   (clk),
    .rst   (rst),
    .oen_q (oen_q),
    .open  (open)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    logic         ready;
    logic         accept;
    logic [W-1:0] tc;
    logic         rail;
    logic [W-1:0] d_r;
    logic         v_r;
    logic         o_r;

    adcf_lane_timer #(.LAT(LAT)) u_timer (
      .clk   (clk),
      .rst   (rst),
      .run_q (run_q[i]),
      .ready (ready)
    );

    adcf_code_conv #(.W(W)) u_conv (
      .code (in_q[i*W +: W]),
      .tc   (tc),
      .rail (rail)
    );

    assign accept = run_q[i] && ready && open;

    // registered lane outputs, blanked when not trusted
    always_ff @(posedge clk) begin
      if (rst) begin
        d_r <= '0;
        v_r <= 1'b0;
        o_r <= 1'b0;
      end else begin
        v_r <= accept;
        d_r <= accept ? tc : '0;
        o_r <= accept && rail;
      end
    end

    assign smp_data[i*W +: W] = d_r;
    assign smp_valid[i]       = v_r;
    assign smp_ovr[i]         = o_r;

    // R4: standby blanks the lane on the next edge
    a_r4_sleep_blank: assert property (@(posedge clk) disable iff (rst)
      !run_q[i] |=> (!v_r && d_r == '0 && !o_r));
    // R6: output disable blanks the lane on the next edge
    a_r6_disable_blank: assert property (@(posedge clk) disable iff (rst)
      oen_q |=> (!v_r && d_r == '0));
    // R2: a valid word is the captured code with its MSB flipped
    a_r2_msb_flip: assert property (@(posedge clk) disable iff (rst)
      v_r |-> (d_r[W-1] == !$past(in_q[i*W + W - 1]) &&
               d_r[W-2:0] == $past(in_q[i*W +: W-1])));
    // R3: over-range only on valid lanes
    a_r3_ovr_needs_valid: assert property (@(posedge clk) disable iff (rst)
      o_r |-> v_r);
  end
endmodule

// File: tb/sim_adcf_capture.sv
module sim_adcf_capture;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int W   = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic [NCH*W-1:0] adc_code;
  logic [NCH-1:0]   ch_run;
  logic             out_en_n;
  logic [NCH*W-1:0] smp_data;
  logic [NCH-1:0]   smp_valid;
  logic [NCH-1:0]   smp_ovr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcf_capture u0 (
    .clk(clk), .rst(rst), .adc_code(adc_code), .ch_run(ch_run),
    .out_en_n(out_en_n), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ovr(smp_ovr)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane(input int i);
    return smp_data[i*W +: W];
  endfunction

  task automatic t_reset();
    rst = 1'b1; ch_run = '1; out_en_n = 1'b0; adc_code = '1;
    step(3);
    chk("R1 valid in reset", 32'(smp_valid), 0);
    chk("R1 data in reset", 32'(smp_data[31:0]), 0);
    chk("R1 ovr in reset", 32'(smp_ovr), 0);
    rst = 1'b0;
    step(1);
    chk("R1 valid after release", 32'(smp_valid), 0);
    step(9);
    chk("R5 all lanes ready after fill", 32'(smp_valid), 32'hFF);
  endtask

  task automatic t_convert();
    for (int i = 0; i < NCH; i++)
      adc_code[i*W +: W] = (i == 0) ? 10'h200 : (i == 1) ? 10'h1FF : 10'(i*73 + 16);
    step(2);
    for (int i = 0; i < NCH; i++) begin
      logic [W-1:0] raw;
      raw = adc_code[i*W +: W];
      chk($sformatf("R2 lane %0d data", i), 32'(lane(i)), 32'(raw ^ 10'h200));
    end
    chk("R3 no ovr mid codes", 32'(smp_ovr), 0);
  endtask

  task automatic t_overrange();
    adc_code[2*W +: W] = 10'h000;
    adc_code[3*W +: W] = 10'h3FF;
    adc_code[4*W +: W] = 10'h001;
    adc_code[5*W +: W] = 10'h3FE;
    step(2);
    chk("R3 ovr pattern", 32'(smp_ovr), 32'h0C);
    chk("R2 lane2 negative rail", 32'(lane(2)), 32'h200);
    chk("R2 lane3 positive rail", 32'(lane(3)), 32'h1FF);
  endtask

  task automatic t_standby();
    ch_run[3] = 1'b0;
    step(1);
    chk("R4 lane3 still valid at edge 1", 32'(smp_valid[3]), 1);
    step(1);
    chk("R4 lane3 invalid", 32'(smp_valid[3]), 0);
    chk("R4 lane3 data zero", 32'(lane(3)), 0);
    chk("R4 lane3 ovr zero", 32'(smp_ovr[3]), 0);
    chk("R8 other lanes valid", 32'(smp_valid), 32'hF7);
    chk("R8 lane2 data kept", 32'(lane(2)), 32'h200);
    step(4);
    chk("R4 lane3 stays invalid", 32'(smp_valid[3]), 0);
  endtask

  task automatic t_exit();
    ch_run[3] = 1'b1;
    step(8);
    chk("R5 lane3 invalid at edge 8", 32'(smp_valid[3]), 0);
    step(1);
    chk("R5 lane3 valid at edge 9", 32'(smp_valid[3]), 1);
    chk("R5 lane3 ovr back", 32'(smp_ovr[3]), 1);
  endtask

  task automatic t_oe();
    out_en_n = 1'b1;
    step(1);
    chk("R6 valid at edge 1", 32'(smp_valid), 32'hFF);
    step(1);
    chk("R6 all invalid", 32'(smp_valid), 0);
    chk("R6 data zero", 32'(smp_data[31:0]), 0);
    chk("R6 ovr zero", 32'(smp_ovr), 0);
    step(12);
    out_en_n = 1'b0;
    step(2);
    chk("R7 still invalid at edge 2", 32'(smp_valid), 0);
    step(1);
    chk("R7 valid at edge 3 no refill", 32'(smp_valid), 32'hFF);
    chk("R7 lane0 data", 32'(lane(0)), 32'h000);
  endtask

  initial begin
    t_reset();
    t_convert();
    t_overrange();
    t_standby();
    t_exit();
    t_oe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule